// File: doc/BRIEF.md
# Multidrop Serial Receiver with Standby Wake-Up

This block is the receive half of an asynchronous serial port for a shared bus with several listeners. It finds start bits on the line, samples each data bit from a 16x oversampling tick, and assembles characters of 8 or 9 data bits, least significant bit first. A completed character is placed in a data register and raises a receive-full flag. A full character time of continuous logic 1 on the line raises an idle flag. Either flag requests an interrupt.

Software can put the receiver into standby with a one-cycle request. In standby it drops traffic meant for other nodes and requests no interrupts. The receiver leaves standby in one of two ways, chosen by a select input. In the line-idle method, an idle preamble wakes the receiver and raises no flag. In the address-mark method, a character whose most significant data bit is 1 wakes the receiver. The wake takes effect as soon as that bit has been sampled, so the address character itself is delivered.

Top module: `mdrx_wake_rx`

## Requirements
- R1: After reset, standby, rx_full, idle_flag and irq are 0 and rx_data is 0.
- R2: In 8-bit mode (nine_bit=0), a frame of one low start bit, 8 data bits sent LSB first and one high stop bit is stored in rx_data[7:0], with rx_data[8]=0. It sets rx_full and irq once the stop bit has been sampled.
- R3: In 9-bit mode (nine_bit=1), 9 data bits are received LSB first into rx_data[8:0].
- R4: A low pulse on rxd shorter than about two ticks fails the start vote, which takes the majority of samples 3, 5 and 7. No character is received from it.
- R5: While awake, idle_flag and irq are set after 10 bit times (160 ticks) of continuous high line in 8-bit mode, or 11 bit times (176 ticks) in 9-bit mode. They are not set before that.
- R6: A pulse on rwu_set sets standby and forces irq to 0 without changing the flags. In standby, a frame whose MSB is 0 is discarded, leaving rx_data and rx_full unchanged.
- R7: With wake_sel=0, an idle preamble clears standby and sets neither idle_flag nor rx_full. Frames after that are received normally.
- R8: With wake_sel=0 in standby, a frame whose MSB is 1 does not wake the receiver and is not delivered.
- R9: With wake_sel=1 in standby, a frame whose MSB is 1 clears standby before its stop bit and is then delivered with rx_full set. The MSB is bit 7 in 8-bit mode and bit 8 in 9-bit mode.
- R10: With wake_sel=1 in standby, an idle preamble neither wakes the receiver nor sets idle_flag.
- R11: A pulse on flag_clr clears rx_full and idle_flag.
- R12: A 9-bit character whose bits are about 3% short (15.5 ticks each) is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | 1: 9 data bits, 0: 8 data bits |
| wake_sel | input | 1 | 0: line-idle wake, 1: address-mark wake |
| rwu_set | input | 1 | One-cycle request to enter standby |
| flag_clr | input | 1 | One-cycle clear of rx_full and idle_flag |
| rx_data | output | 9 | Last delivered character |
| rx_full | output | 1 | Character delivered and not yet cleared |
| idle_flag | output | 1 | Idle line seen while awake |
| standby | output | 1 | Receiver is in standby |
| irq | output | 1 | Receive interrupt request |

## Verification
rxd passes through two synchronizer flops. Each result then appears one clock after the tick that decides it. That tick is sample 9 of the stop bit for rx_full and rx_data, sample 9 of the MSB for an address-mark wake, and the last tick of the preamble for idle_flag and a line-idle wake. The bench therefore samples frame results only after the whole stop bit has been driven, and checks the address-mark wake after the MSB bit ends but before the stop bit starts. Checks on preamble timing are placed at least two bit times away from the threshold on either side, so the few clocks of synchronizer and start latency never change the expected value.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;

    localparam int OVS   = 16;                       // ticks per bit
    localparam int DW    = 9;                        // widest character
    localparam int CW    = $clog2(OVS + 1);          // sample phase width
    localparam int BW    = $clog2(DW);               // bit index width
    localparam int ICW   = $clog2(OVS * (DW + 2) + 1);

    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP
    } rx_state_t;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } frame_t;

    typedef struct packed {
        logic valid;
        logic one;
    } msb_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Preamble length in ticks: start + data + stop bit times.
    function automatic logic [ICW-1:0] idle_limit(input logic nine);
        return nine ? ICW'(OVS * (DW + 2)) : ICW'(OVS * (DW + 1));
    endfunction

endpackage

// File: rtl/mdrx_sampler.sv
module mdrx_sampler
    import mdrx_pkg::*;
#(
    parameter int START_A = 3,
    parameter int START_B = 5,
    parameter int START_C = 7
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   rxd_s,
    input  logic   nine,
    output frame_t frame,
    output msb_t   msb,
    output logic   busy
);

    localparam logic [CW-1:0] SA   = CW'(START_A);
    localparam logic [CW-1:0] SB   = CW'(START_B);
    localparam logic [CW-1:0] SC   = CW'(START_C);
    localparam logic [CW-1:0] DA   = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] DB   = CW'(OVS / 2);
    localparam logic [CW-1:0] DC   = CW'(OVS / 2 + 1);
    localparam logic [CW-1:0] PEND = CW'(OVS);

    rx_state_t     state;
    logic [CW-1:0] ph;
    logic [BW-1:0] bitn;
    logic [1:0]    v;
    logic [DW-1:0] shreg;
    logic          vote;
    logic [BW-1:0] last;

    always_comb begin
        vote = maj3(v[0], v[1], rxd_s);
        last = nine ? BW'(DW - 1) : BW'(DW - 2);
        busy = (state != S_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            ph    <= '0;
            bitn  <= '0;
            v     <= '0;
            shreg <= '0;
            frame <= '0;
            msb   <= '0;
        end else begin
            frame.valid <= 1'b0;
            msb.valid   <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: if (!rxd_s) begin
                        state <= S_START;
                        ph    <= CW'(2);
                        shreg <= '0;
                    end
                    S_START: begin
                        if (ph == SA) v[0] <= rxd_s;
                        if (ph == SB) v[1] <= rxd_s;
                        if (ph == SC && vote) begin
                            state <= S_IDLE;
                        end else if (ph == PEND) begin
                            ph    <= CW'(1);
                            bitn  <= '0;
                            state <= S_DATA;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (ph == DA) v[0] <= rxd_s;
                        if (ph == DB) v[1] <= rxd_s;
                        if (ph == DC) begin
                            shreg[bitn] <= vote;
                            if (bitn == last) begin
                                msb.valid <= 1'b1;
                                msb.one   <= vote;
                            end
                        end
                        if (ph == PEND) begin
                            ph <= CW'(1);
                            if (bitn == last) state <= S_STOP;
                            else              bitn  <= bitn + 1'b1;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (ph == DC) begin
                            frame.valid <= 1'b1;
                            frame.data  <= shreg;
                            state       <= S_IDLE;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    AST_FRAME_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        frame.valid |-> (state == S_IDLE) && $past(state == S_STOP)) else $error("frame"); // R2

endmodule

// File: rtl/mdrx_idle_det.sv
module mdrx_idle_det
    import mdrx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd_s,
    input  logic nine,
    output logic idle_evt
);

    logic [ICW-1:0] cnt;
    logic           armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            armed    <= 1'b1;
            idle_evt <= 1'b0;
        end else begin
            idle_evt <= 1'b0;
            if (!rxd_s) begin
                cnt   <= '0;
                armed <= 1'b1;
            end else if (tick && armed) begin
                if (cnt + 1'b1 >= idle_limit(nine)) begin
                    idle_evt <= 1'b1;
                    armed    <= 1'b0;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mdrx_wake_ctrl.sv
module mdrx_wake_ctrl
    import mdrx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rwu_set,
    input  logic          wake_sel,
    input  logic          flag_clr,
    input  frame_t        frame,
    input  msb_t          msb,
    input  logic          idle_evt,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          idle_flag,
    output logic          standby,
    output logic          irq
);

    logic wake_now;
    logic awake_next;

    always_comb begin
        wake_now   = standby && (wake_sel ? (msb.valid && msb.one) : idle_evt);
        awake_next = !standby && !rwu_set;
        irq        = !standby && (rx_full || idle_flag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            standby   <= 1'b0;
            rx_full   <= 1'b0;
            idle_flag <= 1'b0;
            rx_data   <= '0;
        end else begin
            if (rwu_set)       standby <= 1'b1;
            else if (wake_now) standby <= 1'b0;

            if (frame.valid && awake_next) begin
                rx_full <= 1'b1;
                rx_data <= frame.data;
            end else if (flag_clr) begin
                rx_full <= 1'b0;
            end

            if (idle_evt && awake_next) idle_flag <= 1'b1;
            else if (flag_clr)          idle_flag <= 1'b0;
        end
    end

    AST_FULL_ONLY_AWAKE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> !standby) else $error("full in standby"); // R6
    AST_ADDR_WAKE_MSB: assert property (@(posedge clk) disable iff (rst)
        ($fell(standby) && $past(wake_sel)) |-> $past(msb.valid && msb.one)) else $error("addr wake"); // R9
    AST_IDLE_WAKE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($fell(standby) && !$past(wake_sel)) |-> (!$rose(idle_flag) && !$rose(rx_full))) else $error("idle wake"); // R7

endmodule

// File: rtl/mdrx_wake_rx.sv
module mdrx_wake_rx
    import mdrx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick16,
    input  logic          rxd,
    input  logic          nine_bit,
    input  logic          wake_sel,
    input  logic          rwu_set,
    input  logic          flag_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          idle_flag,
    output logic          standby,
    output logic          irq
);

    logic [1:0] sync_q;
    logic       rxd_s;
    frame_t     frame;
    msb_t       msb;
    logic       busy;
    logic       idle_evt;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end
    assign rxd_s = sync_q[1];

    mdrx_sampler u_sampler (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick16),
        .rxd_s (rxd_s),
        .nine  (nine_bit),
        .frame (frame),
        .msb   (msb),
        .busy  (busy)
    );

    mdrx_idle_det u_idle (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .rxd_s    (rxd_s),
        .nine     (nine_bit),
        .idle_evt (idle_evt)
    );

    mdrx_wake_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rwu_set   (rwu_set),
        .wake_sel  (wake_sel),
        .flag_clr  (flag_clr),
        .frame     (frame),
        .msb       (msb),
        .idle_evt  (idle_evt),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .idle_flag (idle_flag),
        .standby   (standby),
        .irq       (irq)
    );

    // A preamble cannot complete inside a character, so the sampler is idle.
    AST_PREAMBLE_SAMPLER_IDLE: assert property (@(posedge clk) disable iff (rst)
        idle_evt |-> !busy) else $error("preamble while busy"); // R5

endmodule

// File: tb/mdrx_wake_rx_tb.sv
module mdrx_wake_rx_tb;

    localparam int BIT = 32;   // clocks per bit: tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       nine_bit = 1'b0;
    logic       wake_sel = 1'b0;
    logic       rwu_set = 1'b0;
    logic       flag_clr = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, idle_flag, standby, irq;

    int n_chk = 0;
    int n_fail = 0;

    // {nine_bit, data}
    localparam logic [9:0] VEC [0:5] = '{10'h055, 10'h0AA, 10'h0FF,
                                         10'h001, 10'h3C3, 10'h300};

    always #2 clk = ~clk;
    always @(negedge clk) tick16 <= ~tick16;

    mdrx_wake_rx u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .nine_bit(nine_bit), .wake_sel(wake_sel), .rwu_set(rwu_set),
        .flag_clr(flag_clr), .rx_data(rx_data), .rx_full(rx_full),
        .idle_flag(idle_flag), .standby(standby), .irq(irq)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, input int per);
        rxd = b;
        repeat (per) @(negedge clk);
    endtask

    task automatic send_head(input logic nine, input logic [8:0] d, input int per);
        drive_bit(1'b0, per);
        for (int i = 0; i < (nine ? 9 : 8); i++) drive_bit(d[i], per);
    endtask

    task automatic send_frame(input logic nine, input logic [8:0] d, input int per);
        send_head(nine, d, per);
        drive_bit(1'b1, per);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rwu();
        rwu_set = 1'b1;
        @(negedge clk);
        rwu_set = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BIT) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 standby", standby, 0);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 idle", idle_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 data", rx_data, 0);

        // R5 idle preamble timing in 8-bit mode
        wait_bits(8);
        chk("R5 idle early", idle_flag, 0);
        wait_bits(4);
        chk("R5 idle set", idle_flag, 1);
        chk("R5 irq", irq, 1);
        pulse_clr();
        chk("R11 idle clr", idle_flag, 0);
        chk("R11 irq clr", irq, 0);

        // R2/R3 table of frames
        foreach (VEC[k]) begin
            nine_bit = VEC[k][9];
            send_frame(VEC[k][9], VEC[k][8:0], BIT);
            chk(VEC[k][9] ? "R3 data" : "R2 data", rx_data, {23'd0, VEC[k][8:0]});
            chk("R2 rx_full", rx_full, 1);
            chk("R2 irq", irq, 1);
            pulse_clr();
            chk("R11 full clr", rx_full, 0);
        end
        nine_bit = 1'b0;
        wait_bits(12);
        pulse_clr();

        // R4 short glitch rejected
        rxd = 1'b0;
        repeat (2) @(negedge clk);
        rxd = 1'b1;
        wait_bits(12);
        chk("R4 no frame", rx_full, 0);
        chk("R4 data kept", rx_data, 9'h100);
        pulse_clr();

        // R12 fast 9-bit character
        nine_bit = 1'b1;
        send_frame(1'b1, 9'h1A5, BIT - 1);
        chk("R12 data", rx_data, 9'h1A5);
        chk("R12 full", rx_full, 1);
        pulse_clr();
        nine_bit = 1'b0;

        // R6 standby entry and discard
        send_frame(1'b0, 9'h03C, BIT);
        pulse_rwu();
        chk("R6 standby", standby, 1);
        chk("R6 irq quiet", irq, 0);
        chk("R6 full kept", rx_full, 1);
        pulse_clr();
        wake_sel = 1'b1;
        send_frame(1'b0, 9'h035, BIT);
        chk("R6 discard full", rx_full, 0);
        chk("R6 discard data", rx_data, 9'h03C);
        chk("R6 still standby", standby, 1);

        // R10 preamble ignored in address mode
        wait_bits(12);
        chk("R10 standby", standby, 1);
        chk("R10 idle", idle_flag, 0);

        // R9 address-mark wake, 8-bit
        send_head(1'b0, 9'h09A, BIT);
        chk("R9 early wake", standby, 0);
        chk("R9 not yet full", rx_full, 0);
        drive_bit(1'b1, BIT);
        chk("R9 data", rx_data, 9'h09A);
        chk("R9 full", rx_full, 1);
        chk("R9 irq", irq, 1);
        pulse_clr();

        // R9 9-bit: MSB is bit 8
        nine_bit = 1'b1;
        pulse_rwu();
        send_frame(1'b1, 9'h0FF, BIT);
        chk("R9 bit7 no wake", standby, 1);
        chk("R9 bit7 no full", rx_full, 0);
        send_frame(1'b1, 9'h1F0, BIT);
        chk("R9 9b wake", standby, 0);
        chk("R9 9b data", rx_data, 9'h1F0);
        pulse_clr();
        nine_bit = 1'b0;

        // R8 / R7 line-idle method
        wake_sel = 1'b0;
        wait_bits(12);
        pulse_clr();
        pulse_rwu();
        send_frame(1'b0, 9'h081, BIT);
        chk("R8 standby", standby, 1);
        chk("R8 no full", rx_full, 0);
        wait_bits(6);
        chk("R7 not yet", standby, 1);
        wait_bits(6);
        chk("R7 woke", standby, 0);
        chk("R7 no idle", idle_flag, 0);
        chk("R7 no full", rx_full, 0);
        send_frame(1'b0, 9'h012, BIT);
        chk("R7 normal data", rx_data, 9'h012);
        chk("R7 normal full", rx_full, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule